// File: doc/BRIEF.md
# PS/2 Device-Side Frame Transmitter

This block sends bytes from a device, such as a pointing device, to a host over a two-wire PS/2 link. The device side always generates the link clock. Both wires are open-drain. The block therefore produces one drive-low enable for each wire and reads back the resolved level of each wire through a synchronizer. A byte enters through a valid/ready handshake and is held until it has been delivered.

Before it starts a frame, the block waits for the bus to be idle. Idle means both wires are seen high for a programmable number of consecutive cycles. While the host holds the clock low (inhibit), nothing starts. When the host keeps the clock high but pulls data low, it is asking to send. The block flags this on a status output so that a receive path can take over, and it holds off.

Once started, the block shifts out an 11-bit frame and generates every clock pulse itself from a system-clock divider. Each bit period is split into four equal quarters. The clock is released for the first two quarters and pulled low for the last two. The data line changes at the start of the second quarter, which is the middle of the clock-high half. Just before each of the first ten falling edges, the block checks whether the host is holding the clock low. If it is, the frame stops at once, both wires are released, an abort pulse is raised, and the byte stays pending for a later retry. When the whole frame has gone out, a done pulse is raised.

Top module: `ps2_dev_tx`

## Requirements
- R1: `tx_ready` is high exactly when no byte is held. A byte is taken on a cycle with `tx_valid` and `tx_ready` both high. `tx_ready` then stays low until that byte's done pulse. While `tx_ready` is high, neither wire is driven.
- R2: A frame puts 11 bit values on the data line, each one sampled at a falling edge of the generated clock, in this order: start bit 0, the eight data bits least significant first, a parity bit that makes the count of ones in data plus parity odd, and stop bit 1. A data value of 0 means the data line is driven low.
- R3: Each generated clock low phase lasts exactly 2*QUARTER system cycles. Successive falling edges within one frame are exactly 4*QUARTER cycles apart.
- R4: The data drive never changes in the same cycle that the clock drive changes. Each data change happens QUARTER cycles after the clock is released, which is QUARTER cycles before the next falling edge.
- R5: While the host holds the clock line low, no wire is driven. A frame starts only after both lines have been seen high for IDLE_HOLD consecutive cycles. The start bit is then driven QUARTER cycles later.
- R6: Outside a frame, `host_rts` is high whenever the synchronized clock is high and the synchronized data is low. No frame starts during that time.
- R7: If the clock line is sampled low at the check just before any of the first ten falling edges, `tx_abort` pulses for one cycle. Both drives are released in that cycle. The byte stays pending (`tx_ready` low) and is re-sent in full once the bus is idle again.
- R8: A host-driven clock low that arrives after the tenth falling edge (during the stop bit) does not abort the frame. The frame completes with a done pulse.
- R9: `tx_done` pulses for exactly one cycle after the eleventh clock low phase ends. In that cycle `tx_ready` is high again. `tx_done` and `tx_abort` are never high together.
- R10: After reset, `tx_ready` is high, and both drives, `tx_done`, `tx_abort` and `host_rts` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | A byte is offered |
| tx_ready | output | 1 | Block can take a byte |
| ps2_clk_in | input | 1 | Resolved level of the clock wire |
| ps2_dat_in | input | 1 | Resolved level of the data wire |
| ps2_clk_drv | output | 1 | Pull the clock wire low when high |
| ps2_dat_drv | output | 1 | Pull the data wire low when high |
| host_rts | output | 1 | Host is requesting to send |
| tx_done | output | 1 | One-cycle pulse: frame completed |
| tx_abort | output | 1 | One-cycle pulse: frame lost to host contention |

## Verification
All 256 byte values are sent over a quiet bus. Each recorded frame is compared with a start bit, the byte least significant bit first, odd parity and a stop bit, all computed in the bench. This sweep separates bit-order errors from parity errors and framing errors.

A host clock pull is then placed after each number of completed clock pulses from zero to ten. The results show whether the abort window ends at the tenth edge, and whether the retried frame carries the same byte.

Separate runs hold the clock low, and hold data low with the clock high. These distinguish an inhibit from a request-to-send, and they measure how long the block waits for the bus to go idle before it starts.

// File: rtl/ps2tx_pkg.sv
package ps2tx_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_SEND = 2'd2
   } tx_state_e;

   localparam int FRAME_BITS = 11;

   // Bit 0 is sent first: start, byte LSB first, odd parity, stop.
   function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
      return {1'b1, ~(^b), b, 1'b0};
   endfunction

endpackage

// File: rtl/ps2_line_sync.sv
module ps2_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);
   logic [WIDTH-1:0] stg [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[0] <= '1;
      else        stg[0] <= din;
   end

   for (genvar s = 1; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) stg[s] <= '1;
         else        stg[s] <= stg[s-1];
      end
   end

   assign dout = stg[STAGES-1];
endmodule

// File: rtl/ps2_quarter_timer.sv
module ps2_quarter_timer #(
   parameter int QUARTER = 1750
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic last
);
   localparam int CW = (QUARTER > 1) ? $clog2(QUARTER) : 1;
   localparam logic [CW-1:0] TOP = CW'(QUARTER - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          cnt <= '0;
      else if (!run)       cnt <= '0;
      else if (cnt == TOP) cnt <= '0;
      else                 cnt <= cnt + 1'b1;
   end

   assign last = run && (cnt == TOP);
endmodule

// File: rtl/ps2_idle_watch.sv
module ps2_idle_watch #(
   parameter int IDLE_HOLD = 5000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic armed,
   input  logic bus_idle,
   output logic go
);
   localparam int CW = $clog2(IDLE_HOLD + 1);
   localparam logic [CW-1:0] TOP = CW'(IDLE_HOLD - 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  cnt <= '0;
      else if (!armed || !bus_idle) cnt <= '0;
      else if (cnt != TOP)         cnt <= cnt + 1'b1;
   end

   assign go = armed && bus_idle && (cnt == TOP);
endmodule

// File: rtl/ps2_dev_tx.sv
module ps2_dev_tx
   import ps2tx_pkg::*;
#(
   parameter int QUARTER     = 1750,
   parameter int IDLE_HOLD   = 5000,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] tx_data,
   input  logic       tx_valid,
   output logic       tx_ready,
   input  logic       ps2_clk_in,
   input  logic       ps2_dat_in,
   output logic       ps2_clk_drv,
   output logic       ps2_dat_drv,
   output logic       host_rts,
   output logic       tx_done,
   output logic       tx_abort
);
   localparam logic [3:0] LAST_IDX  = 4'(FRAME_BITS - 1);
   localparam logic [3:0] CHECK_MAX = 4'(FRAME_BITS - 2);

   if (QUARTER < SYNC_STAGES + 2) begin : g_bad_quarter
      $error("QUARTER must cover the synchronizer latency");
   end
   if (IDLE_HOLD < 1) begin : g_bad_idle
      $error("IDLE_HOLD must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   tx_state_e             state;
   logic [7:0]            byte_q;
   logic [FRAME_BITS-1:0] shreg;
   logic [3:0]            idx;
   logic [1:0]            phase;
   logic [1:0]            line_s;
   logic                  clk_s, dat_s;
   logic                  q_last, go;

   ps2_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .din  ({ps2_clk_in, ps2_dat_in}),
      .dout (line_s)
   );
   assign clk_s = line_s[1];
   assign dat_s = line_s[0];

   ps2_quarter_timer #(.QUARTER(QUARTER)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (state == ST_SEND),
      .last (q_last)
   );

   ps2_idle_watch #(.IDLE_HOLD(IDLE_HOLD)) u_idle (
      .clk     (clk),
      .rst_n   (rst_n),
      .armed   (state == ST_WAIT),
      .bus_idle(clk_s && dat_s),
      .go      (go)
   );

   assign tx_ready = (state == ST_IDLE);
   assign host_rts = (state != ST_SEND) && clk_s && !dat_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         byte_q      <= '0;
         shreg       <= '0;
         idx         <= '0;
         phase       <= '0;
         ps2_clk_drv <= 1'b0;
         ps2_dat_drv <= 1'b0;
         tx_done     <= 1'b0;
         tx_abort    <= 1'b0;
      end else begin
         tx_done  <= 1'b0;
         tx_abort <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tx_valid) begin
                  byte_q <= tx_data;
                  state  <= ST_WAIT;
               end
            end
            ST_WAIT: begin
               if (go) begin
                  shreg <= build_frame(byte_q);
                  idx   <= '0;
                  phase <= '0;
                  state <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (q_last) begin
                  phase <= phase + 2'd1;
                  unique case (phase)
                     2'd0: ps2_dat_drv <= ~shreg[0];
                     2'd1: begin
                        if (idx <= CHECK_MAX && !clk_s) begin
                           ps2_clk_drv <= 1'b0;
                           ps2_dat_drv <= 1'b0;
                           tx_abort    <= 1'b1;
                           state       <= ST_WAIT;
                        end else begin
                           ps2_clk_drv <= 1'b1;
                        end
                     end
                     2'd2: ;
                     2'd3: begin
                        ps2_clk_drv <= 1'b0;
                        if (idx == LAST_IDX) begin
                           ps2_dat_drv <= 1'b0;
                           tx_done     <= 1'b1;
                           state       <= ST_IDLE;
                        end else begin
                           idx   <= idx + 4'd1;
                           shreg <= shreg >> 1;
                        end
                     end
                     default: ;
                  endcase
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/ps2_dev_tx_chk.sv
module ps2_dev_tx_chk #(
   parameter int QUARTER = 1750
) (
   input logic clk,
   input logic rst_n,
   input logic tx_valid,
   input logic tx_ready,
   input logic ps2_clk_drv,
   input logic ps2_dat_drv,
   input logic host_rts,
   input logic tx_done,
   input logic tx_abort
);
   logic [31:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           low_run <= '0;
      else if (ps2_clk_drv) low_run <= low_run + 32'd1;
      else                  low_run <= '0;
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (!ps2_clk_drv && !ps2_dat_drv));

   assert_take_byte_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   assert_low_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_drv) |-> (low_run == 32'(2 * QUARTER)));

   assert_setup_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ps2_clk_drv) |-> $stable(ps2_dat_drv));

   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ps2_clk_drv) |-> $stable(ps2_dat_drv));

   assert_rts_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      host_rts |-> !ps2_clk_drv);

   assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      tx_abort |-> (!ps2_clk_drv && !ps2_dat_drv && !tx_ready));

   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |=> !tx_done);

   assert_done_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> tx_ready);

   assert_pulse_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_done, tx_abort}));
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.QUARTER(QUARTER)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .tx_valid   (tx_valid),
   .tx_ready   (tx_ready),
   .ps2_clk_drv(ps2_clk_drv),
   .ps2_dat_drv(ps2_dat_drv),
   .host_rts   (host_rts),
   .tx_done    (tx_done),
   .tx_abort   (tx_abort)
);

// File: tb/tb_ps2_dev_tx.sv
`timescale 1ns/1ps
module tb_ps2_dev_tx;
   localparam int Q  = 4;
   localparam int IH = 6;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [7:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready, ps2_clk_drv, ps2_dat_drv, host_rts, tx_done, tx_abort;
   logic host_clk_low = 1'b0;
   logic host_dat_low = 1'b0;
   wire  clk_line = !(ps2_clk_drv || host_clk_low);
   wire  dat_line = !(ps2_dat_drv || host_dat_low);

   always #5 clk = ~clk;

   ps2_dev_tx #(.QUARTER(Q), .IDLE_HOLD(IH), .SYNC_STAGES(SS)) dut (
      .clk(clk), .rst_n(rst_n), .tx_data(tx_data), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .ps2_clk_in(clk_line), .ps2_dat_in(dat_line),
      .ps2_clk_drv(ps2_clk_drv), .ps2_dat_drv(ps2_dat_drv),
      .host_rts(host_rts), .tx_done(tx_done), .tx_abort(tx_abort)
   );

   int compared = 0;
   int mismatched = 0;
   int cyc = 0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // ---------------- monitor ----------------
   logic [10:0] exp_frame = '0;
   logic [10:0] cap = '0;
   int  nbits = 0;
   int  frames_done = 0;
   int  aborts = 0;
   int  low_run = 0;
   int  since_fall = 0;
   bit  prev_drv = 1'b0;
   bit  any_drive = 1'b0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (ps2_clk_drv || ps2_dat_drv) any_drive = 1'b1;
         since_fall++;
         if (ps2_clk_drv && !prev_drv) begin
            if (nbits > 0)
               check(since_fall == 4*Q, "R3 fall spacing", since_fall, 4*Q);
            cap = {dat_line, cap[10:1]};
            nbits++;
            since_fall = 0;
         end
         if (ps2_clk_drv) low_run++;
         else if (prev_drv) begin
            check(low_run == 2*Q, "R3 low width", low_run, 2*Q);
            low_run = 0;
         end
         if (tx_done) begin
            frames_done++;
            check(nbits == 11, "R2 bit count", nbits, 11);
            check(cap == exp_frame, "R2 frame", int'(cap), int'(exp_frame));
            check(tx_ready == 1'b1, "R9 ready at done", int'(tx_ready), 1);
            nbits = 0;
         end
         if (tx_abort) begin
            aborts++;
            nbits = 0;
         end
         prev_drv = ps2_clk_drv;
      end
   end

   task automatic offer(input logic [7:0] b);
      exp_frame = {1'b1, ~(^b), b, 1'b0};
      while (!tx_ready) @(negedge clk);
      tx_data  = b;
      tx_valid = 1'b1;
      @(negedge clk);
      tx_valid = 1'b0;
      check(tx_ready == 1'b0, "R1 ready drops", int'(tx_ready), 0);
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      finish_run();
   end

   initial begin
      int n, a0, t0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(tx_ready == 1'b1, "R10 ready", int'(tx_ready), 1);
      check(ps2_clk_drv == 1'b0 && ps2_dat_drv == 1'b0, "R10 drives", int'({ps2_clk_drv, ps2_dat_drv}), 0);
      check(tx_done == 1'b0 && tx_abort == 1'b0, "R10 pulses", int'({tx_done, tx_abort}), 0);
      check(host_rts == 1'b0, "R10 rts", int'(host_rts), 0);

      // R2 sweep of every byte value on a quiet bus
      for (int b = 0; b < 256; b++) begin
         n = frames_done;
         offer(8'(b));
         wait (frames_done == n + 1);
         @(negedge clk);
      end

      // R5 inhibit: clock held low by host
      host_clk_low = 1'b1;
      any_drive = 1'b0;
      n = frames_done;
      offer(8'h3C);
      repeat (200) @(negedge clk);
      check(any_drive == 1'b0, "R5 no drive under inhibit", int'(any_drive), 0);
      check(tx_ready == 1'b0, "R5 byte pending", int'(tx_ready), 0);
      host_clk_low = 1'b0;
      t0 = cyc;
      while (!ps2_dat_drv) @(negedge clk);
      check((cyc - t0) >= IH + Q && (cyc - t0) <= IH + Q + SS + 2,
            "R5 start delay", cyc - t0, IH + Q);
      wait (frames_done == n + 1);
      @(negedge clk);

      // R6 host request-to-send
      host_dat_low = 1'b1;
      any_drive = 1'b0;
      n = frames_done;
      offer(8'hC3);
      repeat (50) @(negedge clk);
      check(host_rts == 1'b1, "R6 rts flagged", int'(host_rts), 1);
      check(any_drive == 1'b0, "R6 no start", int'(any_drive), 0);
      host_dat_low = 1'b0;
      wait (frames_done == n + 1);
      @(negedge clk);
      check(host_rts == 1'b0, "R6 rts cleared", int'(host_rts), 0);

      // R7 / R8 contention after k completed clock pulses
      for (int k = 0; k <= 10; k++) begin
         n  = frames_done;
         a0 = aborts;
         offer(8'hA5 ^ 8'(k * 17));
         if (k == 0) wait (ps2_dat_drv);
         else        wait (nbits == k && !ps2_clk_drv);
         @(negedge clk);
         host_clk_low = 1'b1;
         repeat (4 * Q) @(negedge clk);
         if (k < 10) begin
            check(aborts == a0 + 1, "R7 abort seen", aborts - a0, 1);
            check(tx_ready == 1'b0, "R7 byte kept", int'(tx_ready), 0);
         end
         host_clk_low = 1'b0;
         wait (frames_done == n + 1);
         @(negedge clk);
         if (k < 10) check(aborts == a0 + 1, "R7 single abort then retry", aborts - a0, 1);
         else        check(aborts == a0, "R8 late pull ignored", aborts - a0, 0);
      end

      repeat (10) @(negedge clk);
      finish_run();
   end
endmodule